// File: doc/BRIEF.md
# Interrupt Controller with Atomic Acknowledge

This block collects interrupt requests from a set of input lines into a status register. It gates that register with a mask register and drives one registered interrupt output to the processor core. Software reaches it through a small register bus made of an address, write data, a write strobe and registered read data.

Each line is sensed either on its rising edge or on its level, selected per line. The status register can still be written directly, as older software expects, and a direct write replaces the whole value. Two further write-only registers close the read-modify-write hazard:

- The acknowledge register clears every status bit written as one, in a single write cycle.
- The set register raises every status bit written as one, so software can post an interrupt itself.

An edge that arrives while software is acknowledging another line, or the same line, is therefore never dropped.

Top module: `irq_ctrl`

## Requirements
- R1: After synchronous reset the mask, mode and status registers all read zero and `irq_o` is low.
- R2: `irq_o` is registered. It is high exactly one cycle after a cycle in which (status AND mask) has any bit set, and low one cycle after that AND is zero.
- R3: Register addresses: 0 = mask, 1 = mode, 2 = status, 3 = acknowledge, 4 = set. Mask, mode and status read back their current value. Addresses 3 and 4 and any unused address read zero. `rdata` is registered, so it is valid one cycle after the address is presented.
- R4: A write to address 2 replaces the whole status value with the written data. A bit whose line is asserting in that cycle, as defined in R7 and R8, is ORed in.
- R5: A write to address 3 clears each status bit where the data bit is one and leaves bits written as zero unchanged.
- R6: A write to address 4 ORs the written data into status.
- R7: A line whose mode bit is 1 is edge sensed. An input that is high in a cycle and was low in the previous cycle sets its status bit, which then stays set after the input falls until it is cleared by software.
- R8: A line whose mode bit is 0 is level sensed. Its status bit is set in the cycle after the input is seen high, and an acknowledge or a direct write cannot clear it while the input stays high. After the input falls, the bit holds until it is cleared.
- R9: A rising edge on a line in the same cycle as an acknowledge of that line's bit leaves the bit set. An acknowledge of one bit never disturbs an edge captured on another line in that cycle.
- R10: A status bit whose mask bit is 0 does not cause `irq_o` to rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Interrupt request lines, synchronous to clk |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | N_LINES | Register write data |
| rdata | output | N_LINES | Registered read data |
| irq_o | output | 1 | Combined interrupt to the core |

## Verification
Each result has a fixed latency:

- A register write or an input edge or level lands in status on the clock edge that samples it.
- Read data follows one edge after the address is presented.
- `irq_o` follows one edge after the status or mask change.

The bench drives all inputs on falling edges. It reads status through a one-cycle read and samples `rdata` and `irq_o` on the next falling edge, so every check falls in the cycle where its value is due. The race cases put the acknowledge write and the input change in the same falling-edge slot, so both reach the same rising edge.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_MASK = 3'd0,
    RA_MODE = 3'd1,
    RA_STAT = 3'd2,
    RA_ACK  = 3'd3,
    RA_SET  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [N_LINES-1:0] wdata,
  input  logic [N_LINES-1:0] status,
  output logic [N_LINES-1:0] mask_q,
  output logic [N_LINES-1:0] mode_q,
  output logic               st_wr,
  output logic [N_LINES-1:0] ack_bits,
  output logic [N_LINES-1:0] set_bits,
  output logic [N_LINES-1:0] rdata
);
  localparam logic [N_LINES-1:0] ZERO = '0;

  // write strobes towards the status bits
  always_comb begin
    st_wr    = we && (addr == RA_STAT);
    ack_bits = (we && (addr == RA_ACK)) ? wdata : ZERO;
    set_bits = (we && (addr == RA_SET)) ? wdata : ZERO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= ZERO;
      mode_q <= ZERO;
    end else if (we) begin
      if (addr == RA_MASK) mask_q <= wdata;
      if (addr == RA_MODE) mode_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= ZERO;
    end else begin
      case (addr)
        RA_MASK: rdata <= mask_q;
        RA_MODE: rdata <= mode_q;
        RA_STAT: rdata <= status;
        default: rdata <= ZERO;
      endcase
    end
  end
endmodule

// File: rtl/irq_line.sv
module irq_line (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic rise_i,
  input  logic edge_mode_i,
  input  logic st_wr_i,
  input  logic st_wval_i,
  input  logic ack_i,
  input  logic set_i,
  output logic pend_o
);
  logic nxt;

  always_comb begin
    nxt = st_wr_i ? st_wval_i : pend_o;
    nxt = nxt & ~ack_i;
    nxt = nxt | set_i;
    // hardware request applied last so it beats any clear
    nxt = nxt | (edge_mode_i ? rise_i : req_i);
  end

  always_ff @(posedge clk) begin
    if (rst) pend_o <= 1'b0;
    else     pend_o <= nxt;
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [N_LINES-1:0] wdata,
  output logic [N_LINES-1:0] rdata,
  output logic               irq_o
);
  logic [N_LINES-1:0] mask_q, mode_q, status_q, in_q, rise;
  logic [N_LINES-1:0] ack_bits, set_bits;
  logic               st_wr;

  irq_regs #(.N_LINES(N_LINES)) u_regs (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
    .status(status_q), .mask_q(mask_q), .mode_q(mode_q),
    .st_wr(st_wr), .ack_bits(ack_bits), .set_bits(set_bits),
    .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) in_q <= '0;
    else     in_q <= irq_in;
  end

  assign rise = irq_in & ~in_q;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    irq_line u_line (
      .clk(clk), .rst(rst),
      .req_i(irq_in[i]), .rise_i(rise[i]), .edge_mode_i(mode_q[i]),
      .st_wr_i(st_wr), .st_wval_i(wdata[i]),
      .ack_i(ack_bits[i]), .set_i(set_bits[i]),
      .pend_o(status_q[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_q & mask_q);
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               we,
  input logic [ADDR_W-1:0]  addr,
  input logic [N_LINES-1:0] wdata,
  input logic [N_LINES-1:0] irq_in,
  input logic [N_LINES-1:0] in_q,
  input logic [N_LINES-1:0] status,
  input logic [N_LINES-1:0] mask,
  input logic [N_LINES-1:0] mode,
  input logic               irq_o
);
  logic [N_LINES-1:0] lvl_act, edge_act, ack_clr;

  always_comb begin
    lvl_act  = irq_in & ~mode;
    edge_act = irq_in & ~in_q & mode;
    ack_clr  = (we && addr == RA_ACK) ? (wdata & ~lvl_act & ~edge_act) : '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!irq_o && status == '0)); // R1
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst) (|(status & mask)) |=> irq_o); // R2
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst) !(|(status & mask)) |=> !irq_o); // R10
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst) (|ack_clr) |=> ((status & $past(ack_clr)) == '0)); // R5
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst) (we && addr == RA_SET) |=> ((status & $past(wdata)) == $past(wdata))); // R6
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst) (|lvl_act) |=> ((status & $past(lvl_act)) == $past(lvl_act))); // R8
  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst) (|edge_act) |=> ((status & $past(edge_act)) == $past(edge_act))); // R9
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
  .irq_in(irq_in), .in_q(in_q), .status(status_q), .mask(mask_q),
  .mode(mode_q), .irq_o(irq_o)
);

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic         we = 1'b0;
  logic [2:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  irq_ctrl #(.N_LINES(N)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk); we = 1'b0; addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    rd(3'd0, v); chk("R1 mask", v, '0);
    rd(3'd1, v); chk("R1 mode", v, '0);
    rd(3'd2, v); chk("R1 status", v, '0);
    chk("R1 irq_o", {{(N-1){1'b0}}, irq_o}, '0);
  endtask

  task automatic t_readback();
    logic [N-1:0] v;
    wr(3'd0, 8'h3C); rd(3'd0, v); chk("R3 mask readback", v, 8'h3C);
    wr(3'd1, 8'hC3); rd(3'd1, v); chk("R3 mode readback", v, 8'hC3);
    wr(3'd4, 8'h01); rd(3'd3, v); chk("R3 ack reads zero", v, '0);
    rd(3'd4, v); chk("R3 set reads zero", v, '0);
    rd(3'd6, v); chk("R3 unused reads zero", v, '0);
    wr(3'd2, '0); wr(3'd0, '0); wr(3'd1, '0);
  endtask

  task automatic t_direct();
    logic [N-1:0] v;
    wr(3'd2, 8'hA5); rd(3'd2, v); chk("R4 direct write", v, 8'hA5);
    wr(3'd2, 8'h0F); rd(3'd2, v); chk("R4 replaces whole value", v, 8'h0F);
    wr(3'd2, '0);
  endtask

  task automatic t_set_ack();
    logic [N-1:0] v;
    wr(3'd4, 8'h81); wr(3'd4, 8'h10); rd(3'd2, v);
    chk("R6 set ORs in", v, 8'h91);
    wr(3'd3, 8'h11); rd(3'd2, v);
    chk("R5 ack clears ones only", v, 8'h80);
    wr(3'd3, 8'h00); rd(3'd2, v);
    chk("R5 zero ack no effect", v, 8'h80);
    wr(3'd2, '0);
  endtask

  task automatic t_edge();
    logic [N-1:0] v;
    wr(3'd1, 8'h03);
    @(negedge clk); irq_in[0] = 1'b1;
    @(negedge clk); irq_in[0] = 1'b0;
    rd(3'd2, v); chk("R7 edge latched after fall", v, 8'h01);
    wr(3'd3, 8'h01); rd(3'd2, v); chk("R7 ack clears edge bit", v, 8'h00);
    @(negedge clk); irq_in[1] = 1'b1;
    repeat (2) @(negedge clk);
    wr(3'd3, 8'h02); rd(3'd2, v);
    chk("R7 held input gives one edge only", v, 8'h00);
    irq_in[1] = 1'b0;
  endtask

  task automatic t_race();
    logic [N-1:0] v;
    wr(3'd4, 8'h01);
    // new edge on line 0 and on line 1 in the same cycle as ack of bit 0
    @(negedge clk); we = 1'b1; addr = 3'd3; wdata = 8'h01; irq_in[1:0] = 2'b11;
    @(negedge clk); we = 1'b0; irq_in[1:0] = 2'b00;
    rd(3'd2, v); chk("R9 edge beats ack, other line kept", v, 8'h03);
    wr(3'd3, 8'h03); wr(3'd1, 8'h00);
  endtask

  task automatic t_level();
    logic [N-1:0] v;
    @(negedge clk); irq_in[2] = 1'b1;
    rd(3'd2, v); chk("R8 level sets status", v, 8'h04);
    wr(3'd3, 8'h04); rd(3'd2, v); chk("R8 ack ignored while high", v, 8'h04);
    wr(3'd2, 8'h00); rd(3'd2, v); chk("R4 R8 direct write ORs active level", v, 8'h04);
    @(negedge clk); irq_in[2] = 1'b0;
    rd(3'd2, v); chk("R8 holds after fall", v, 8'h04);
    wr(3'd3, 8'h04); rd(3'd2, v); chk("R8 cleared after fall", v, 8'h00);
  endtask

  task automatic t_mask();
    wr(3'd4, 8'h20);
    @(negedge clk);
    chk("R10 masked bit no irq", {{(N-1){1'b0}}, irq_o}, '0);
    wr(3'd0, 8'h20);
    // mask lands on the write edge, irq_o one edge later
    chk("R2 irq_o not yet", {{(N-1){1'b0}}, irq_o}, '0);
    @(negedge clk);
    chk("R2 irq_o asserted", {{(N-1){1'b0}}, irq_o}, 8'h01);
    wr(3'd3, 8'h20);
    @(negedge clk);
    chk("R2 irq_o deasserted", {{(N-1){1'b0}}, irq_o}, '0);
    wr(3'd0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readback();
    t_direct();
    t_set_ack();
    t_edge();
    t_race();
    t_level();
    t_mask();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule